// File: doc/BRIEF.md
# Burst Column Address Sequencer

This block produces the column addresses of one synchronous DRAM burst. A single-cycle start pulse captures an 8-bit start column, a 3-bit burst length code and an ordering bit. From the next cycle on, the block presents one column address per clock. Each address comes with a valid flag, and a last flag marks the final beat. Finite bursts end by themselves. A full-page burst keeps walking the whole column space until a terminate input ends it.

Two orderings are available. Sequential ordering counts up inside an aligned block the size of the burst. Interleave ordering XORs the beat number into the low column bits. A combination that is not allowed raises a one-cycle error pulse and produces no addresses. The block is meant to sit between a mode-register decoder and a column command issuer, which consumes the address stream.

Top module: `burst_colgen`

## Requirements
- R1: `ilv_mode` = 0 selects sequential ordering and 1 selects interleave ordering. `blen` codes are 000 = 1 beat, 001 = 2, 010 = 4, 011 = 8 and 111 = full page; 100, 101 and 110 are reserved.
- R2: A legal `start` sampled at a clock edge makes the next cycle show `col_valid` = 1 with `col_addr` equal to the captured start column. Each later edge advances the burst by one beat.
- R3: In a sequential finite burst of N beats, beat k keeps the column bits above log2(N) equal to the start column. Its low log2(N) bits equal (start + k) mod N.
- R4: In an interleave burst of 4 or 8 beats, beat k equals the start column with bits [log2(N)-1:0] XORed with k. The upper bits stay fixed.
- R5: A full-page burst issues (start + k) mod 256 on beat k, so it returns to the start column after 256 beats. It continues until `terminate` is high on a valid beat. That beat carries `col_last`, and `col_valid` is low on the following cycle.
- R6: In a finite burst, `col_last` is high together with beat N-1 only. Unless a new start arrives, `col_valid` is low in the cycle after it.
- R7: `terminate` has no effect during a finite burst or while idle.
- R8: A start with a reserved length code, or with interleave and a length other than 4 or 8, gives `cfg_err` = 1 for exactly one cycle with `col_valid` = 0. It also abandons any burst in progress.
- R9: A legal start during an active burst abandons the old burst. The next cycle shows beat 0 of the new burst.
- R10: After reset, `col_valid`, `col_last` and `cfg_err` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begin a burst with the values on the inputs below |
| start_col | input | 8 | Start column address |
| blen | input | 3 | Burst length code |
| ilv_mode | input | 1 | Ordering select: 0 sequential, 1 interleave |
| terminate | input | 1 | Ends a full-page burst on the current beat |
| col_addr | output | 8 | Column address of the current beat |
| col_valid | output | 1 | `col_addr` holds a beat |
| col_last | output | 1 | Current beat is the final one |
| cfg_err | output | 1 | One-cycle pulse on an illegal start |

## Verification
The assertions assume that `start_col`, `blen` and `ilv_mode` matter only in the cycle where `start` is high, and that `terminate` is a level input sampled on the same edge as the beat it ends. The driver changes inputs only a short time after a rising edge and drops `start` after one cycle. It raises `terminate` only in the cycle whose beat it means to end, except in the deliberate test that holds it high through a finite burst. The scoreboard expects each beat exactly once and in order. Any extra valid cycle after a last beat, or a beat that never appears, counts as a miscompare.

// File: rtl/colgen_pkg.sv
package colgen_pkg;

   typedef enum logic [2:0] {
      BL_ONE  = 3'b000,
      BL_TWO  = 3'b001,
      BL_FOUR = 3'b010,
      BL_EIGHT= 3'b011,
      BL_PAGE = 3'b111
   } blen_e;

   typedef struct packed {
      logic       legal;   // combination may start a burst
      logic       full;    // full-page burst
      logic       ilv;     // interleave ordering
      logic [2:0] lg;      // log2 of finite length
   } cfg_t;

endpackage

// File: rtl/colgen_decode.sv
module colgen_decode
   import colgen_pkg::*;
#(
   parameter bit ILV_EN = 1'b1
) (
   input  logic [2:0] blen,
   input  logic       ilv,
   output cfg_t       cfg
);

   logic ilv_ok;

   generate
      if (ILV_EN) begin : g_ilv
         assign ilv_ok = 1'b1;
      end else begin : g_no_ilv
         assign ilv_ok = ~ilv;
      end
   endgenerate

   always_comb begin
      cfg     = '0;
      cfg.ilv = ilv;
      unique case (blen_e'(blen))
         BL_ONE:   begin cfg.lg = 3'd0; cfg.legal = ~ilv;  end
         BL_TWO:   begin cfg.lg = 3'd1; cfg.legal = ~ilv;  end
         BL_FOUR:  begin cfg.lg = 3'd2; cfg.legal = ilv_ok; end
         BL_EIGHT: begin cfg.lg = 3'd3; cfg.legal = ilv_ok; end
         BL_PAGE:  begin cfg.full = 1'b1; cfg.legal = ~ilv; end
         default:  cfg.legal = 1'b0;
      endcase
   end

   // R4
   always_comb begin
      if (cfg.legal && cfg.ilv)
         ilv_len_chk: assert (!cfg.full && (cfg.lg == 3'd2 || cfg.lg == 3'd3));
   end

endmodule

// File: rtl/colgen_addr.sv
module colgen_addr #(
   parameter int unsigned COL_W = 8
) (
   input  logic [COL_W-1:0] base,
   input  logic [COL_W-1:0] beat,
   input  logic [COL_W-1:0] mask,
   input  logic             ilv,
   output logic [COL_W-1:0] addr
);

   logic [COL_W-1:0] sum_v;
   logic [COL_W-1:0] xor_v;

   assign sum_v = base + beat;
   assign xor_v = base ^ beat;

   generate
      for (genvar i = 0; i < COL_W; i++) begin : g_bit
         assign addr[i] = mask[i] ? (ilv ? xor_v[i] : sum_v[i]) : base[i];
      end
   endgenerate

endmodule

// File: rtl/burst_colgen.sv
module burst_colgen
   import colgen_pkg::*;
#(
   parameter int unsigned COL_W  = 8,
   parameter bit          ILV_EN = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   input  logic [COL_W-1:0] start_col,
   input  logic [2:0]       blen,
   input  logic             ilv_mode,
   input  logic             terminate,
   output logic [COL_W-1:0] col_addr,
   output logic             col_valid,
   output logic             col_last,
   output logic             cfg_err
);

   localparam int unsigned MAX_FIN_LOG = 3;

   generate
      if (COL_W <= MAX_FIN_LOG) begin : g_bad_width
         $error("COL_W must exceed the largest finite burst width");
      end
   endgenerate

   cfg_t             cfg;
   logic [COL_W-1:0] mask_n;
   logic             active_q;
   logic             full_q;
   logic             ilv_q;
   logic             err_q;
   logic [COL_W-1:0] base_q;
   logic [COL_W-1:0] beat_q;
   logic [COL_W-1:0] mask_q;

   colgen_decode #(.ILV_EN(ILV_EN)) u_dec (
      .blen (blen),
      .ilv  (ilv_mode),
      .cfg  (cfg)
   );

   always_comb begin
      if (cfg.full) mask_n = '1;
      else          mask_n = (COL_W'(1) << cfg.lg) - COL_W'(1);
   end

   colgen_addr #(.COL_W(COL_W)) u_addr (
      .base (base_q),
      .beat (beat_q),
      .mask (mask_q),
      .ilv  (ilv_q),
      .addr (col_addr)
   );

   assign col_valid = active_q;
   assign cfg_err   = err_q;
   assign col_last  = active_q & (full_q ? terminate : (beat_q == mask_q));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         active_q <= 1'b0;
         full_q   <= 1'b0;
         ilv_q    <= 1'b0;
         err_q    <= 1'b0;
         base_q   <= '0;
         beat_q   <= '0;
         mask_q   <= '0;
      end else if (start) begin
         active_q <= cfg.legal;
         err_q    <= ~cfg.legal;
         if (cfg.legal) begin
            full_q <= cfg.full;
            ilv_q  <= cfg.ilv;
            base_q <= start_col;
            beat_q <= '0;
            mask_q <= mask_n;
         end
      end else begin
         err_q <= 1'b0;
         if (active_q) begin
            if (col_last) active_q <= 1'b0;
            else          beat_q   <= beat_q + COL_W'(1);
         end
      end
   end

   // R5
   last_has_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
      col_last |-> col_valid);

   // R8
   err_no_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_err |-> !col_valid);

   // R8
   illegal_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
      start && !cfg.legal |=> cfg_err && !col_valid);

   // R2
   first_beat_chk: assert property (@(posedge clk) disable iff (!rst_n)
      start && cfg.legal |=> col_valid && col_addr == $past(start_col));

   // R6
   burst_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
      col_last && !start |=> !col_valid && !cfg_err);

   // R3
   beat_advance_chk: assert property (@(posedge clk) disable iff (!rst_n)
      col_valid && !col_last && !start |=> col_valid && col_addr != $past(col_addr));

endmodule

// File: tb/sim_burst_colgen.sv
`timescale 1ns/1ps
module sim_burst_colgen;

   typedef struct {
      logic [7:0] a;
      logic       l;
      string      r;
   } item_t;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       start = 1'b0;
   logic [7:0] start_col = '0;
   logic [2:0] blen = '0;
   logic       ilv_mode = 1'b0;
   logic       terminate = 1'b0;
   logic [7:0] col_addr;
   logic       col_valid;
   logic       col_last;
   logic       cfg_err;

   int vectors = 0;
   int miscompares = 0;
   bit done = 1'b0;
   item_t expq[$];

   always #5 clk = ~clk;

   burst_colgen u0 (
      .clk(clk), .rst_n(rst_n), .start(start), .start_col(start_col),
      .blen(blen), .ilv_mode(ilv_mode), .terminate(terminate),
      .col_addr(col_addr), .col_valid(col_valid), .col_last(col_last),
      .cfg_err(cfg_err)
   );

   // expected address from R3, R4, R5
   function automatic logic [7:0] exp_addr(logic [7:0] col, logic [2:0] code,
                                           bit ilv, int k);
      logic [7:0] m;
      logic [7:0] kk;
      kk = 8'(k);
      m  = (code == 3'b111) ? 8'hFF : 8'((1 << code) - 1);
      if (ilv) return (col & ~m) | ((col ^ kk) & m);
      return (col & ~m) | ((col + kk) & m);
   endfunction

   task automatic check(bit ok, string tag, string what, int act, int exp);
      vectors++;
      if (!ok) begin
         miscompares++;
         $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
      end
   endtask

   task automatic push(logic [7:0] col, logic [2:0] code, bit ilv,
                       int nbeats, int last_idx, string tag);
      for (int k = 0; k < nbeats; k++) begin
         item_t it;
         it.a = exp_addr(col, code, ilv, k);
         it.l = (k == last_idx);
         it.r = tag;
         expq.push_back(it);
      end
   endtask

   // full page: term_idx is the beat ending it
   task automatic run_burst(logic [7:0] col, logic [2:0] code, bit ilv,
                            int term_idx, bit hold_term, string tag);
      int n;
      n = (code == 3'b111) ? term_idx + 1 : (1 << code);
      push(col, code, ilv, n, n - 1, tag);
      @(posedge clk); #2;
      start = 1'b1; start_col = col; blen = code; ilv_mode = ilv;
      terminate = hold_term;
      @(posedge clk); #2;
      start = 1'b0;
      if (code == 3'b111) begin
         repeat (term_idx) begin @(posedge clk); #2; end
         terminate = 1'b1;
         @(posedge clk); #2;
      end else begin
         repeat (n) @(posedge clk);
         #2;
      end
      terminate = 1'b0;
   endtask

   // monitor: pops and compares each valid beat
   initial begin
      forever begin
         @(negedge clk);
         if (rst_n && col_valid) begin
            if (expq.size() == 0) begin
               check(1'b0, "R6", "unexpected beat addr", col_addr, -1);
            end else begin
               item_t it;
               it = expq.pop_front();
               check(col_addr == it.a, it.r, "addr", col_addr, it.a);
               check(col_last == it.l, it.r, "last", col_last, it.l);
            end
         end
      end
   end

   initial begin
      #2_000_000;
      if (!done) begin
         miscompares++;
         $display("FAIL watchdog expired");
         $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
         $finish;
      end
   end

   initial begin
      repeat (3) @(posedge clk);
      #2 rst_n = 1'b1;
      @(negedge clk);
      // R10 reset state
      check(!col_valid, "R10", "valid", col_valid, 0);
      check(!col_last,  "R10", "last",  col_last, 0);
      check(!cfg_err,   "R10", "err",   cfg_err, 0);

      // R1 R2 R3 R6: sequential finite lengths
      run_burst(8'h3D, 3'b000, 1'b0, 0, 1'b0, "R6");
      run_burst(8'h3D, 3'b001, 1'b0, 0, 1'b0, "R3");
      run_burst(8'h3E, 3'b010, 1'b0, 0, 1'b0, "R3");
      run_burst(8'hFD, 3'b011, 1'b0, 0, 1'b0, "R3");
      run_burst(8'h00, 3'b011, 1'b0, 0, 1'b0, "R2");
      // R4 interleave
      run_burst(8'hA6, 3'b011, 1'b1, 0, 1'b0, "R4");
      run_burst(8'h57, 3'b010, 1'b1, 0, 1'b0, "R4");
      run_burst(8'h95, 3'b011, 1'b1, 0, 1'b0, "R1");
      // R5 full page, wraps past 255 and back to start
      run_burst(8'hFA, 3'b111, 1'b0, 300, 1'b0, "R5");
      run_burst(8'h10, 3'b111, 1'b0, 0, 1'b0, "R5");
      // R7 terminate held through finite bursts
      run_burst(8'h21, 3'b011, 1'b0, 0, 1'b1, "R7");
      run_burst(8'h21, 3'b010, 1'b1, 0, 1'b1, "R7");
      // R7 terminate while idle
      @(posedge clk); #2 terminate = 1'b1;
      repeat (3) begin
         @(negedge clk);
         check(!col_valid && !col_last, "R7", "idle valid/last", col_valid, 0);
      end
      @(posedge clk); #2 terminate = 1'b0;

      // R8 illegal combinations, idle
      for (int c = 0; c < 8; c++) begin
         for (int iv = 0; iv < 2; iv++) begin
            bit legal;
            legal = (iv == 0) ? (c <= 3 || c == 7) : (c == 2 || c == 3);
            if (!legal) begin
               @(posedge clk); #2;
               start = 1'b1; blen = 3'(c); ilv_mode = iv[0]; start_col = 8'h44;
               @(posedge clk); #2 start = 1'b0;
               @(negedge clk);
               check(cfg_err && !col_valid, "R8", "err pulse", cfg_err, 1);
               @(negedge clk);
               check(!cfg_err && !col_valid, "R8", "err one cycle", cfg_err, 0);
            end
         end
      end

      // R9 restart during a burst
      push(8'h30, 3'b011, 1'b0, 3, -1, "R9");
      push(8'h72, 3'b010, 1'b1, 4, 3, "R9");
      @(posedge clk); #2;
      start = 1'b1; start_col = 8'h30; blen = 3'b011; ilv_mode = 1'b0;
      @(posedge clk); #2 start = 1'b0;
      repeat (2) begin @(posedge clk); #2; end
      start = 1'b1; start_col = 8'h72; blen = 3'b010; ilv_mode = 1'b1;
      @(posedge clk); #2 start = 1'b0;
      repeat (4) @(posedge clk);
      #2;

      // R8 illegal start abandons an active burst
      push(8'h80, 3'b011, 1'b0, 2, -1, "R8");
      @(posedge clk); #2;
      start = 1'b1; start_col = 8'h80; blen = 3'b011; ilv_mode = 1'b0;
      @(posedge clk); #2 start = 1'b0;
      @(posedge clk); #2;
      start = 1'b1; blen = 3'b000; ilv_mode = 1'b1;
      @(posedge clk); #2 start = 1'b0;
      @(negedge clk);
      check(cfg_err && !col_valid, "R8", "abort err", cfg_err, 1);
      repeat (3) @(negedge clk);
      check(!col_valid, "R8", "stays idle", col_valid, 0);

      repeat (3) @(posedge clk);
      check(expq.size() == 0, "R2", "beats missing", expq.size(), 0);
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
   end

endmodule